// File: doc/BRIEF.md
# Edge-Filtered Status Group

This block watches a 16-bit vector of live status conditions and records chosen changes in it. Each condition bit can be set to record a rise, a fall, or both. Two programmable masks make this choice. A recorded change sets a sticky event bit. That bit stays set until software reads the event register or a global clear pulse arrives. An enable mask selects which event bits feed a single summary output. The summary is high whenever any enabled event bit is set.

Several groups can be stacked into a tree. The summary output of one instance drives one condition input of a parent instance.

A simple register port gives software access to the block:
- the sampled condition vector, read-only;
- the three masks, read and write;
- the event register, where a read clears the bits it returned.

Two further inputs act on the whole block. A preset pulse returns the masks to fixed defaults. A clear pulse empties the event register.

Top module: `stat_group`

## Requirements
- R1: The register map is: address 0 condition (read-only), 1 rising-edge mask, 2 falling-edge mask, 3 summary enable mask, 4 event register. Other addresses read 0. Read data is combinational from `regAddr`. The condition register takes the value of `condIn` one clock after it is driven. A write to address 0 has no effect.
- R2: If a bit is set in the rising-edge mask and its sampled condition goes 0→1, the matching event bit becomes 1 one clock later.
- R3: If a bit is set in the falling-edge mask and its sampled condition goes 1→0, the matching event bit becomes 1. A bit set in both masks records either edge. Edges on bits enabled in neither mask are not recorded.
- R4: An event bit stays at 1 after its condition returns to its former level, until it is read or cleared.
- R5: A cycle with `regRdEn` high at address 4 returns the event contents on `regRdData`. After that clock edge, every bit it returned is 0.
- R6: An edge that is recorded in the same cycle as a destructive read or a clear pulse is present in the event register afterwards.
- R7: `summary` equals the OR over all bits of (event AND enable mask).
- R8: `presetPulse` loads the rising mask with 0x7FFF and loads the falling and enable masks with 0. It does not change the event register.
- R9: Bit 15 reads as 0 in every register, whatever is written or driven on it.
- R10: After reset the rising mask is 0x7FFF, and the falling mask, enable mask, event register and `summary` are all 0.
- R11: `clearPulse` sets the event register to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| condIn | input | 16 | Live condition vector |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; at address 4 it clears the event register |
| regAddr | input | 3 | Register address |
| regWrData | input | 16 | Write data |
| clearPulse | input | 1 | Clears the event register |
| presetPulse | input | 1 | Loads the mask defaults |
| regRdData | output | 16 | Read data for `regAddr` |
| summary | output | 1 | OR of enabled event bits |

## Verification
The bench walks a table of mask settings paired with condition before and after values. The cases are:
- rising only;
- falling only;
- both edges on interleaved bits;
- masks that cover only half of a changing vector;
- no mask at all;
- bit 15 toggling.

Each case isolates one filtering path, so a swapped mask or an inverted edge shows up as a wrong event word.

Directed tests then cover the remaining behaviour:
- stickiness after the condition has gone away;
- summary gating by the enable mask;
- clear and preset;
- an edge that lands in exactly the cycle of a destructive read.

The last case separates "kept" from "lost".

// File: rtl/stat_group_pkg.sv
package stat_group_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_COND = 3'd0,
    ADDR_RISE = 3'd1,
    ADDR_FALL = 3'd2,
    ADDR_EN   = 3'd3,
    ADDR_EVT  = 3'd4
  } regAddrE;

  typedef struct packed {
    logic wrRise;
    logic wrFall;
    logic wrEnable;
    logic rdEvent;
    logic clrEvent;
    logic loadPreset;
  } ctrlStrobeT;

endpackage

// File: rtl/stat_group_ctrl.sv
module stat_group_ctrl
  import stat_group_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              clearPulse,
  input  logic              presetPulse,
  output ctrlStrobeT        strobe
);

  always_comb begin
    strobe            = '0;
    strobe.wrRise     = regWrEn && (regAddr == ADDR_RISE);
    strobe.wrFall     = regWrEn && (regAddr == ADDR_FALL);
    strobe.wrEnable   = regWrEn && (regAddr == ADDR_EN);
    strobe.rdEvent    = regRdEn && (regAddr == ADDR_EVT);
    strobe.clrEvent   = clearPulse;
    strobe.loadPreset = presetPulse;
  end

  AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrRise, strobe.wrFall, strobe.wrEnable})); // R1

  AST_COND_READONLY: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_COND) |-> !(strobe.wrRise || strobe.wrFall || strobe.wrEnable)); // R1

endmodule

// File: rtl/stat_group_dp.sv
module stat_group_dp
  import stat_group_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [WIDTH-1:0]  condIn,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WIDTH-1:0]  rdData,
  output logic              summary
);

  localparam logic [WIDTH-1:0] LIVE_MASK   = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] RISE_PRESET = LIVE_MASK;
  localparam logic [WIDTH-1:0] FALL_PRESET = '0;
  localparam logic [WIDTH-1:0] EN_PRESET   = '0;

  logic [WIDTH-1:0] condReg, prevCond;
  logic [WIDTH-1:0] riseMask, fallMask, enMask;
  logic [WIDTH-1:0] evtReg, evtNext, edgeHit;
  logic             evtDrop;

  // sampled condition and its previous value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      condReg  <= '0;
      prevCond <= '0;
    end else begin
      condReg  <= condIn & LIVE_MASK;
      prevCond <= condReg;
    end
  end

  // mask registers, preset has priority over writes
  always_ff @(posedge clk) begin
    if (!rstN || strobe.loadPreset) begin
      riseMask <= RISE_PRESET;
      fallMask <= FALL_PRESET;
      enMask   <= EN_PRESET;
    end else begin
      if (strobe.wrRise)   riseMask <= wrData & LIVE_MASK;
      if (strobe.wrFall)   fallMask <= wrData & LIVE_MASK;
      if (strobe.wrEnable) enMask   <= wrData & LIVE_MASK;
    end
  end

  assign evtDrop = strobe.rdEvent | strobe.clrEvent;

  // per-bit edge filter and sticky event cell
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_evtBit
    assign edgeHit[gi] = (condReg[gi] & ~prevCond[gi] & riseMask[gi])
                       | (~condReg[gi] & prevCond[gi] & fallMask[gi]);
    assign evtNext[gi] = ((evtReg[gi] & ~evtDrop) | edgeHit[gi]) & LIVE_MASK[gi];
  end

  always_ff @(posedge clk) begin
    if (!rstN) evtReg <= '0;
    else       evtReg <= evtNext;
  end

  assign summary = |(evtReg & enMask);

  always_comb begin
    unique case (rdAddr)
      ADDR_COND: rdData = condReg;
      ADDR_RISE: rdData = riseMask;
      ADDR_FALL: rdData = fallMask;
      ADDR_EN:   rdData = enMask;
      ADDR_EVT:  rdData = evtReg;
      default:   rdData = '0;
    endcase
  end

  AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|(condReg & ~prevCond & riseMask)) |=>
      ((evtReg & $past(condReg & ~prevCond & riseMask)) == $past(condReg & ~prevCond & riseMask))); // R2

  AST_FALL_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|(~condReg & prevCond & fallMask)) |=>
      ((evtReg & $past(~condReg & prevCond & fallMask)) == $past(~condReg & prevCond & fallMask))); // R3

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !evtDrop |=> ((evtReg & $past(evtReg)) == $past(evtReg))); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEvent |=> ((evtReg & ~$past(edgeHit)) == '0)); // R5

  AST_CLEAR_KEEPS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (evtDrop && |edgeHit) |=> ((evtReg & $past(edgeHit)) == $past(edgeHit))); // R6

  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPreset |=> (riseMask == RISE_PRESET && fallMask == '0 && enMask == '0)); // R8

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[WIDTH-1] == 1'b0); // R9

endmodule

// File: rtl/stat_group.sv
module stat_group
  import stat_group_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  condIn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWrData,
  input  logic              clearPulse,
  input  logic              presetPulse,
  output logic [WIDTH-1:0]  regRdData,
  output logic              summary
);

  ctrlStrobeT strobe;

  stat_group_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regAddr     (regAddr),
    .clearPulse  (clearPulse),
    .presetPulse (presetPulse),
    .strobe      (strobe)
  );

  stat_group_dp #(.WIDTH(WIDTH)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .condIn  (condIn),
    .wrData  (regWrData),
    .rdAddr  (regAddr),
    .rdData  (regRdData),
    .summary (summary)
  );

endmodule

// File: tb/test_stat_group.sv
module test_stat_group;
  import stat_group_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] condIn = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWrData = '0;
  logic        clearPulse = 1'b0, presetPulse = 1'b0;
  logic [15:0] regRdData;
  logic        summary;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk; // 250 MHz

  stat_group i_stat_group (
    .clk(clk), .rstN(rstN), .condIn(condIn), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .clearPulse(clearPulse),
    .presetPulse(presetPulse), .regRdData(regRdData), .summary(summary)
  );

  // {riseMask, fallMask, condBefore, condAfter, expectedEvent}
  localparam logic [79:0] VEC [6] = '{
    {16'h7FFF, 16'h0000, 16'h0000, 16'h00F0, 16'h00F0},
    {16'h0000, 16'hFFFF, 16'h00FF, 16'h000F, 16'h00F0},
    {16'h0F0F, 16'h0F0F, 16'h00FF, 16'hFF00, 16'h0F0F},
    {16'h00FF, 16'hFF00, 16'h0000, 16'hFFFF, 16'h00FF},
    {16'h0000, 16'h0000, 16'h1234, 16'hEDCB, 16'h0000},
    {16'h8001, 16'h8001, 16'h0000, 16'h8001, 16'h0001}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic doRead(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    peek(ADDR_RISE, v); check("R10 rise mask", v, 16'h7FFF);
    peek(ADDR_FALL, v); check("R10 fall mask", v, 16'h0000);
    peek(ADDR_EN, v);   check("R10 enable", v, 16'h0000);
    peek(ADDR_EVT, v);  check("R10 event", v, 16'h0000);
    check("R10 summary", {15'd0, summary}, 16'h0000);

    // R1 condition tracking, read-only, unmapped address
    condIn = 16'h1234;
    @(negedge clk);
    peek(ADDR_COND, v); check("R1 condition", v, 16'h1234);
    doWrite(ADDR_COND, 16'h0F0F);
    peek(ADDR_COND, v); check("R1 condition write ignored", v, 16'h1234);
    peek(3'd6, v); check("R1 unmapped read", v, 16'h0000);
    condIn = 16'hFFFF;
    @(negedge clk);
    peek(ADDR_COND, v); check("R9 condition bit15", v, 16'h7FFF);

    // R2/R3/R9 table walk
    for (int i = 0; i < 6; i++) begin
      logic [15:0] rm, fm, c0, c1, ex;
      {rm, fm, c0, c1, ex} = VEC[i];
      doWrite(ADDR_RISE, rm);
      doWrite(ADDR_FALL, fm);
      peek(ADDR_RISE, v); check("R9 rise mask readback", v, rm & 16'h7FFF);
      peek(ADDR_FALL, v); check("R9 fall mask readback", v, fm & 16'h7FFF);
      condIn = c0;
      repeat (3) @(negedge clk);
      doRead(ADDR_EVT, v);
      condIn = c1;
      repeat (3) @(negedge clk);
      peek(ADDR_EVT, v); check("R2 R3 event vector", v, ex);
    end

    // R5 destructive read
    doRead(ADDR_EVT, v); check("R5 read returns event", v, 16'h0001);
    peek(ADDR_EVT, v); check("R5 event cleared by read", v, 16'h0000);

    // R4 sticky: bit0 rises then falls, rising mask only
    doWrite(ADDR_RISE, 16'h7FFF);
    doWrite(ADDR_FALL, 16'h0000);
    condIn = 16'h0000;
    repeat (3) @(negedge clk);
    doRead(ADDR_EVT, v);
    condIn = 16'h0001;
    repeat (3) @(negedge clk);
    condIn = 16'h0000;
    repeat (3) @(negedge clk);
    peek(ADDR_EVT, v); check("R4 sticky after condition gone", v, 16'h0001);

    // R7 summary gating
    check("R7 summary with enable 0", {15'd0, summary}, 16'h0000);
    doWrite(ADDR_EN, 16'h0002);
    check("R7 summary with other bit enabled", {15'd0, summary}, 16'h0000);
    doWrite(ADDR_EN, 16'h0001);
    check("R7 summary with bit enabled", {15'd0, summary}, 16'h0001);

    // R11 clear pulse
    @(negedge clk); clearPulse = 1'b1;
    @(negedge clk); clearPulse = 1'b0;
    peek(ADDR_EVT, v); check("R11 clear empties event", v, 16'h0000);
    check("R11 summary after clear", {15'd0, summary}, 16'h0000);

    // R6 edge coinciding with a destructive read
    condIn = 16'h0001;
    repeat (3) @(negedge clk);   // bit0 event set
    condIn = 16'h0003;           // bit1 rises, captured at next edge
    @(negedge clk);              // edge on bit1 detected in this cycle
    regRdEn = 1'b1; regAddr = ADDR_EVT;
    #1 v = regRdData;
    check("R6 read data before edge lands", v, 16'h0001);
    @(negedge clk);
    regRdEn = 1'b0;
    peek(ADDR_EVT, v); check("R6 coincident edge kept", v, 16'h0002);

    // R8 preset
    doWrite(ADDR_RISE, 16'h0003);
    doWrite(ADDR_FALL, 16'h0005);
    doWrite(ADDR_EN, 16'h0007);
    @(negedge clk); presetPulse = 1'b1;
    @(negedge clk); presetPulse = 1'b0;
    peek(ADDR_RISE, v); check("R8 preset rise", v, 16'h7FFF);
    peek(ADDR_FALL, v); check("R8 preset fall", v, 16'h0000);
    peek(ADDR_EN, v);   check("R8 preset enable", v, 16'h0000);
    peek(ADDR_EVT, v);  check("R8 event untouched by preset", v, 16'h0002);

    finishRun();
  end

endmodule